// File: doc/BRIEF.md
# Register Window Decoder

This block is an AXI4-Lite slave for 32-bit register traffic. It steers each access by address to one of three downstream register windows: one for the host-memory traffic generator, one for the external DRAM traffic generator and one for the on-chip high-bandwidth-memory traffic generator. Each window is a plain request/acknowledge register port. The block also holds one local status/control register for the memory controller. That register drives the controller's soft reset and reports its initialization state.

Only one transaction is in flight at a time. For a write, the address channel and the data channel may arrive in either order. For a read, the address is captured and the chosen target is queried. Every response is a single beat. Addresses that map to no window and are not the status register give a fixed error word on reads. Writes to such addresses are accepted and dropped.

Top module: `regWindowDecoder`

## Requirements
- R1: Byte offsets 0x000–0x0FF select window 0, 0x100–0x1FF select window 1 and 0x200–0x2FF select window 2. Exactly one `winReq` bit is raised, and it stays high until its `winAck` bit is seen. While it is high, `winAddr` carries offset bits [7:0], `winWe` gives the direction and, on writes, `winWdata` and `winWstrb` carry the data and strobes. A window read returns that window's `winRdata` slice, which is bits [32*i+31:32*i] for window i.
- R2: A read from any address that is not in a window and not at 0x300–0x303 returns 32'hDEADBEEF with an OKAY response. This covers 0x304–0x3FF and everything from 0x400 up. No window request is raised.
- R3: A write to such an unmapped address completes with an OKAY response. It raises no window request and changes no local state.
- R4: A read of 0x300 returns the soft-reset control value in bit 0 and the two-flop-synchronized `memInitIn` in bits [2:1]. Bits [31:3] read as zero.
- R5: A write to 0x300 with `wStrb[0]` set loads `wData[0]` into the soft-reset control, and that value drives `memSwReset`. Writes to bits [31:1], and writes with `wStrb[0]` clear, leave the register unchanged.
- R6: For a write, AW and W may arrive in either order or together. `bValid` is never raised before both have been accepted, and no window request is raised before then either.
- R7: While a transaction is in progress, `arReady` and `awReady` stay low. This lasts until its response has been accepted.
- R8: Every response is OKAY (2'b00). `bValid` or `rValid` stays high until the matching ready is seen, and `rData` is held steady while `rValid` waits.
- R9: After reset, `bValid`, `rValid`, `winReq` and `memSwReset` are low and `arReady` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| awAddr | input | ADDR_W | Write address |
| awValid | input | 1 | Write address valid |
| awReady | output | 1 | Write address ready |
| wData | input | 32 | Write data |
| wStrb | input | 4 | Write byte strobes |
| wValid | input | 1 | Write data valid |
| wReady | output | 1 | Write data ready |
| bResp | output | 2 | Write response |
| bValid | output | 1 | Write response valid |
| bReady | input | 1 | Write response ready |
| arAddr | input | ADDR_W | Read address |
| arValid | input | 1 | Read address valid |
| arReady | output | 1 | Read address ready |
| rData | output | 32 | Read data |
| rResp | output | 2 | Read response |
| rValid | output | 1 | Read data valid |
| rReady | input | 1 | Read data ready |
| winReq | output | WIN_NUM | Per-window access request |
| winWe | output | 1 | Window access is a write |
| winAddr | output | WIN_AW | Offset inside the window |
| winWdata | output | 32 | Window write data |
| winWstrb | output | 4 | Window write strobes |
| winAck | input | WIN_NUM | Per-window acknowledge |
| winRdata | input | WIN_NUM*32 | Per-window read data, window i in slice i |
| memInitIn | input | 2 | Memory initialized flags, asynchronous |
| memSwReset | output | 1 | Memory controller soft reset |

## Verification
Suppose the latched address or the decode is wrong. The first access to the wrong target then shows it: a request appears on the wrong `winReq` bit, or a read returns the wrong word, within a few cycles of the address handshake. Suppose instead the handshake tracking is wrong. Then `bValid` rises after only one of AW or W has been accepted, or a ready rises while a response is still waiting, and both are visible within the cycle after the fault. A lost soft-reset bit appears on `memSwReset` and on the next read of 0x300.

// File: rtl/regwin_pkg.sv
package regwin_pkg;
  typedef struct packed {
    logic capAw;
    logic capW;
    logic capAr;
    logic access;
    logic isWrite;
    logic finish;
  } ctrlStrobe_t;

  localparam logic [31:0] UNMAPPED_WORD = 32'hDEAD_BEEF;
  localparam logic [1:0]  RESP_OKAY     = 2'b00;
endpackage

// File: rtl/regwin_ctrl.sv
module regwin_ctrl
  import regwin_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        awValid,
  output logic        awReady,
  input  logic        wValid,
  output logic        wReady,
  input  logic        arValid,
  output logic        arReady,
  output logic        bValid,
  input  logic        bReady,
  output logic        rValid,
  input  logic        rReady,
  input  logic        tgtIsWin,
  input  logic        selAck,
  output ctrlStrobe_t strb
);
  typedef enum logic [1:0] {ST_IDLE, ST_ACCESS, ST_RESP} state_e;

  state_e state;
  logic awSeen, wSeen, isWr;
  logic idle, arHs, awHs, wHs, wrGo, done;

  always_comb begin
    idle    = (state == ST_IDLE);
    arReady = idle && !awSeen && !wSeen;
    arHs    = arValid && arReady;
    awReady = idle && !awSeen && !arHs;
    wReady  = idle && !wSeen && !arHs;
    awHs    = awValid && awReady;
    wHs     = wValid && wReady;
    wrGo    = (awSeen || awHs) && (wSeen || wHs);
    done    = tgtIsWin ? selAck : 1'b1;

    strb.capAw   = awHs;
    strb.capW    = wHs;
    strb.capAr   = arHs;
    strb.access  = (state == ST_ACCESS);
    strb.isWrite = isWr;
    strb.finish  = (state == ST_ACCESS) && done;

    bValid = (state == ST_RESP) && isWr;
    rValid = (state == ST_RESP) && !isWr;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      awSeen <= 1'b0;
      wSeen  <= 1'b0;
      isWr   <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (arHs) begin
            state <= ST_ACCESS;
            isWr  <= 1'b0;
          end else if (wrGo) begin
            state  <= ST_ACCESS;
            isWr   <= 1'b1;
            awSeen <= 1'b0;
            wSeen  <= 1'b0;
          end else begin
            if (awHs) awSeen <= 1'b1;
            if (wHs)  wSeen  <= 1'b1;
          end
        end
        ST_ACCESS: if (done) state <= ST_RESP;
        ST_RESP:   if (isWr ? bReady : rReady) state <= ST_IDLE;
        default:   state <= ST_IDLE;
      endcase
    end
  end

  AST_SINGLE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rstN)
    (bValid || rValid) |-> !(arReady || awReady || wReady)); // R7
  AST_B_WAITS_BOTH: assert property (@(posedge clk) disable iff (!rstN)
    (awSeen ^ wSeen) |=> !bValid); // R6
  AST_B_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (bValid && !bReady) |=> bValid); // R8
  AST_R_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (rValid && !rReady) |=> rValid); // R8
  AST_NO_DUAL_RESP: assert property (@(posedge clk) disable iff (!rstN)
    !(bValid && rValid)); // R8
endmodule

// File: rtl/regwin_dp.sv
module regwin_dp
  import regwin_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 32,
  parameter int WIN_NUM = 3,
  parameter int WIN_AW  = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  ctrlStrobe_t               strb,
  input  logic [ADDR_W-1:0]         awAddr,
  input  logic [ADDR_W-1:0]         arAddr,
  input  logic [DATA_W-1:0]         wData,
  input  logic [DATA_W/8-1:0]       wStrb,
  input  logic [WIN_NUM-1:0]        winAck,
  input  logic [WIN_NUM*DATA_W-1:0] winRdata,
  input  logic [1:0]                memInitIn,
  output logic                      tgtIsWin,
  output logic                      selAck,
  output logic [WIN_NUM-1:0]        winReq,
  output logic                      winWe,
  output logic [WIN_AW-1:0]         winAddr,
  output logic [DATA_W-1:0]         winWdata,
  output logic [DATA_W/8-1:0]       winWstrb,
  output logic [DATA_W-1:0]         rData,
  output logic                      memSwReset
);
  localparam int SEL_W = $clog2(WIN_NUM + 1);
  localparam int DEC_W = WIN_AW + SEL_W;
  localparam logic [ADDR_W-1:0] STAT_OFF = ADDR_W'(WIN_NUM) << WIN_AW;

  logic [ADDR_W-1:0]   addrQ;
  logic [DATA_W-1:0]   dataQ, rDataQ, winSel, statWord, rdNext;
  logic [DATA_W/8-1:0] strbQ;
  logic [1:0]          initS1, initS2;
  logic                swRstQ;
  logic [SEL_W-1:0]    winIdx;
  logic                highZero, isStat;

  always_comb begin
    winIdx   = addrQ[WIN_AW +: SEL_W];
    highZero = (addrQ[ADDR_W-1:DEC_W] == '0);
    tgtIsWin = highZero && (int'(winIdx) < WIN_NUM);
    isStat   = (addrQ[ADDR_W-1:2] == STAT_OFF[ADDR_W-1:2]);
    statWord = {{(DATA_W-3){1'b0}}, initS2, swRstQ};
    winSel   = '0;
    for (int i = 0; i < WIN_NUM; i++) begin
      if (winIdx == SEL_W'(i)) winSel = winRdata[i*DATA_W +: DATA_W];
    end
    if (tgtIsWin)    rdNext = winSel;
    else if (isStat) rdNext = statWord;
    else             rdNext = UNMAPPED_WORD[DATA_W-1:0];
  end

  for (genvar g = 0; g < WIN_NUM; g++) begin : gWinReq
    assign winReq[g] = strb.access && tgtIsWin && (winIdx == SEL_W'(g));
  end

  assign selAck     = |(winAck & winReq);
  assign winWe      = strb.isWrite;
  assign winAddr    = addrQ[WIN_AW-1:0];
  assign winWdata   = dataQ;
  assign winWstrb   = strbQ;
  assign rData      = rDataQ;
  assign memSwReset = swRstQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ  <= '0;
      dataQ  <= '0;
      strbQ  <= '0;
      rDataQ <= '0;
      swRstQ <= 1'b0;
      initS1 <= '0;
      initS2 <= '0;
    end else begin
      initS1 <= memInitIn;
      initS2 <= initS1;
      if (strb.capAw) addrQ <= awAddr;
      if (strb.capAr) addrQ <= arAddr;
      if (strb.capW) begin
        dataQ <= wData;
        strbQ <= wStrb;
      end
      if (strb.finish && !strb.isWrite) rDataQ <= rdNext;
      if (strb.finish && strb.isWrite && isStat && strbQ[0]) swRstQ <= dataQ[0];
    end
  end

  AST_WIN_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(winReq)); // R1
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    ((|winReq) && !selAck) |=> ($stable(winReq) && $stable(winAddr))); // R1
  AST_SWRST_ONLY_STAT: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(swRstQ) |-> $past(strb.finish && strb.isWrite && isStat)); // R5
endmodule

// File: rtl/regWindowDecoder.sv
module regWindowDecoder
  import regwin_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int WIN_NUM = 3,
  parameter int WIN_AW  = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [ADDR_W-1:0]     awAddr,
  input  logic                  awValid,
  output logic                  awReady,
  input  logic [31:0]           wData,
  input  logic [3:0]            wStrb,
  input  logic                  wValid,
  output logic                  wReady,
  output logic [1:0]            bResp,
  output logic                  bValid,
  input  logic                  bReady,
  input  logic [ADDR_W-1:0]     arAddr,
  input  logic                  arValid,
  output logic                  arReady,
  output logic [31:0]           rData,
  output logic [1:0]            rResp,
  output logic                  rValid,
  input  logic                  rReady,
  output logic [WIN_NUM-1:0]    winReq,
  output logic                  winWe,
  output logic [WIN_AW-1:0]     winAddr,
  output logic [31:0]           winWdata,
  output logic [3:0]            winWstrb,
  input  logic [WIN_NUM-1:0]    winAck,
  input  logic [WIN_NUM*32-1:0] winRdata,
  input  logic [1:0]            memInitIn,
  output logic                  memSwReset
);
  ctrlStrobe_t strb;
  logic tgtIsWin, selAck;

  regwin_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .awValid(awValid), .awReady(awReady),
    .wValid(wValid), .wReady(wReady),
    .arValid(arValid), .arReady(arReady),
    .bValid(bValid), .bReady(bReady),
    .rValid(rValid), .rReady(rReady),
    .tgtIsWin(tgtIsWin), .selAck(selAck),
    .strb(strb)
  );

  regwin_dp #(.ADDR_W(ADDR_W), .DATA_W(32), .WIN_NUM(WIN_NUM), .WIN_AW(WIN_AW)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .awAddr(awAddr), .arAddr(arAddr), .wData(wData), .wStrb(wStrb),
    .winAck(winAck), .winRdata(winRdata), .memInitIn(memInitIn),
    .tgtIsWin(tgtIsWin), .selAck(selAck),
    .winReq(winReq), .winWe(winWe), .winAddr(winAddr),
    .winWdata(winWdata), .winWstrb(winWstrb),
    .rData(rData), .memSwReset(memSwReset)
  );

  assign bResp = RESP_OKAY;
  assign rResp = RESP_OKAY;

  AST_RDATA_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (rValid && !rReady) |=> $stable(rData)); // R8
endmodule

// File: tb/regWindowDecoder_tb.sv
module regWindowDecoder_tb;
  localparam int AW = 12;
  localparam int NW = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [AW-1:0] awAddr = '0, arAddr = '0;
  logic awValid = 0, wValid = 0, bReady = 0, arValid = 0, rReady = 0;
  logic [31:0] wData = '0;
  logic [3:0] wStrb = '0;
  logic awReady, wReady, bValid, arReady, rValid, winWe, memSwReset;
  logic [1:0] bResp, rResp;
  logic [31:0] rData, winWdata;
  logic [NW-1:0] winReq;
  logic [NW-1:0] winAck = '0;
  logic [7:0] winAddr;
  logic [3:0] winWstrb;
  logic [NW*32-1:0] winRdata;
  logic [1:0] memInitIn = 2'b00;

  int total = 0, bad = 0, cycles = 0;
  int hits [NW];
  int cnt [NW];
  logic [7:0]  lastAddr [NW];
  logic [31:0] lastData [NW];
  logic [3:0]  lastStrb [NW];
  logic        lastWe   [NW];

  always #10 clk = ~clk;

  regWindowDecoder u_dut (
    .clk(clk), .rstN(rstN),
    .awAddr(awAddr), .awValid(awValid), .awReady(awReady),
    .wData(wData), .wStrb(wStrb), .wValid(wValid), .wReady(wReady),
    .bResp(bResp), .bValid(bValid), .bReady(bReady),
    .arAddr(arAddr), .arValid(arValid), .arReady(arReady),
    .rData(rData), .rResp(rResp), .rValid(rValid), .rReady(rReady),
    .winReq(winReq), .winWe(winWe), .winAddr(winAddr),
    .winWdata(winWdata), .winWstrb(winWstrb),
    .winAck(winAck), .winRdata(winRdata),
    .memInitIn(memInitIn), .memSwReset(memSwReset)
  );

  // window model: answers after i+1 cycles, read word {A, i, 0000, offset}
  always_comb begin
    for (int i = 0; i < NW; i++)
      winRdata[i*32 +: 32] = {4'hA, 4'(i), 16'h0, winAddr};
  end

  initial begin
    for (int i = 0; i < NW; i++) begin
      hits[i] = 0; cnt[i] = 0;
      lastAddr[i] = '0; lastData[i] = '0; lastStrb[i] = '0; lastWe[i] = 1'b0;
    end
  end

  always @(posedge clk) begin
    for (int i = 0; i < NW; i++) begin
      if (winReq[i] && !winAck[i]) begin
        if (cnt[i] == i + 1) begin
          winAck[i]   <= 1'b1;
          cnt[i]      <= 0;
          hits[i]     <= hits[i] + 1;
          lastAddr[i] <= winAddr;
          lastData[i] <= winWdata;
          lastStrb[i] <= winWstrb;
          lastWe[i]   <= winWe;
        end else cnt[i] <= cnt[i] + 1;
      end else winAck[i] <= 1'b0;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      total++; bad++;
      $display("FAIL R7 watchdog actual=hung expected=complete");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic sendAw(input logic [AW-1:0] a);
    @(negedge clk); awAddr = a; awValid = 1'b1; #1;
    while (!awReady) begin @(negedge clk); #1; end
    @(posedge clk); #1; awValid = 1'b0;
  endtask

  task automatic sendW(input logic [31:0] d, input logic [3:0] s);
    @(negedge clk); wData = d; wStrb = s; wValid = 1'b1; #1;
    while (!wReady) begin @(negedge clk); #1; end
    @(posedge clk); #1; wValid = 1'b0;
  endtask

  task automatic sendAwW(input logic [AW-1:0] a, input logic [31:0] d, input logic [3:0] s);
    @(negedge clk); awAddr = a; awValid = 1'b1; wData = d; wStrb = s; wValid = 1'b1; #1;
    while (!(awReady && wReady)) begin @(negedge clk); #1; end
    @(posedge clk); #1; awValid = 1'b0; wValid = 1'b0;
  endtask

  task automatic waitB(input string tag);
    @(negedge clk); #1;
    while (!bValid) begin @(negedge clk); #1; end
    check(bResp == 2'b00, {tag, " R8 bResp"}, 32'(bResp), 32'h0);
    @(negedge clk); #1;
    check(bValid, {tag, " R8 bValid held"}, 32'(bValid), 32'h1);
    check(!awReady && !arReady, {tag, " R7 ready low while B waits"}, {awReady, arReady}, 32'h0);
    bReady = 1'b1;
    @(posedge clk); #1; bReady = 1'b0;
  endtask

  task automatic readWord(input logic [AW-1:0] a, output logic [31:0] d, input string tag);
    logic [31:0] first;
    @(negedge clk); arAddr = a; arValid = 1'b1; #1;
    while (!arReady) begin @(negedge clk); #1; end
    @(posedge clk); #1; arValid = 1'b0;
    @(negedge clk); #1;
    while (!rValid) begin @(negedge clk); #1; end
    first = rData;
    check(rResp == 2'b00, {tag, " R8 rResp"}, 32'(rResp), 32'h0);
    @(negedge clk); #1;
    check(rValid && rData == first, {tag, " R8 rData held"}, rData, first);
    check(!awReady && !arReady, {tag, " R7 ready low while R waits"}, {awReady, arReady}, 32'h0);
    d = rData;
    rReady = 1'b1;
    @(posedge clk); #1; rReady = 1'b0;
  endtask

  task automatic testReset();
    @(negedge clk);
    check(!bValid && !rValid, "R9 no valid after reset", {bValid, rValid}, 32'h0);
    check(winReq == '0, "R9 no window request", 32'(winReq), 32'h0);
    check(!memSwReset, "R9 soft reset low", 32'(memSwReset), 32'h0);
    check(arReady, "R9 arReady high", 32'(arReady), 32'h1);
  endtask

  task automatic testWinRead();
    logic [31:0] d;
    for (int i = 0; i < NW; i++) begin
      int h = hits[i];
      readWord(AW'(i * 256 + 'h24), d, "R1 window read");
      check(d == {4'hA, 4'(i), 16'h0, 8'h24}, "R1 window read data", d, {4'hA, 4'(i), 16'h0, 8'h24});
      check(hits[i] == h + 1 && lastWe[i] == 1'b0, "R1 window read hit", 32'(hits[i]), 32'(h + 1));
    end
  endtask

  task automatic testWinWrite();
    int h;
    h = hits[1];
    sendAwW(12'h13C, 32'h1111_2222, 4'hF);
    waitB("R6 together");
    check(hits[1] == h + 1 && lastAddr[1] == 8'h3C && lastData[1] == 32'h1111_2222 && lastWe[1],
          "R1 window1 write", lastData[1], 32'h1111_2222);
    h = hits[2];
    sendAw(12'h2F0);
    repeat (3) @(negedge clk);
    check(!bValid && winReq == '0, "R6 AW only gives no response", {bValid, 3'(winReq)}, 32'h0);
    sendW(32'hCAFE_0002, 4'b0101);
    waitB("R6 aw first");
    check(hits[2] == h + 1 && lastAddr[2] == 8'hF0 && lastStrb[2] == 4'b0101,
          "R1 window2 write", {lastAddr[2], lastStrb[2]}, {8'hF0, 4'b0101});
    h = hits[0];
    sendW(32'h0BAD_F00D, 4'hF);
    repeat (3) @(negedge clk);
    check(!bValid && winReq == '0, "R6 W only gives no response", {bValid, 3'(winReq)}, 32'h0);
    sendAw(12'h008);
    waitB("R6 w first");
    check(hits[0] == h + 1 && lastData[0] == 32'h0BAD_F00D && lastAddr[0] == 8'h08,
          "R1 window0 write", lastData[0], 32'h0BAD_F00D);
  endtask

  task automatic testUnmappedRead();
    logic [31:0] d;
    logic [AW-1:0] addrs [4] = '{12'h304, 12'h3FC, 12'h400, 12'hFFC};
    for (int k = 0; k < 4; k++) begin
      int s = hits[0] + hits[1] + hits[2];
      readWord(addrs[k], d, "R2 unmapped");
      check(d == 32'hDEAD_BEEF, "R2 unmapped read word", d, 32'hDEAD_BEEF);
      check(hits[0] + hits[1] + hits[2] == s, "R2 no window hit", 32'(hits[0] + hits[1] + hits[2]), 32'(s));
    end
  endtask

  task automatic testUnmappedWrite();
    logic [31:0] d;
    int s = hits[0] + hits[1] + hits[2];
    sendAwW(12'h304, 32'h1, 4'hF);
    waitB("R3 unmapped 304");
    sendAwW(12'h400, 32'h1, 4'hF);
    waitB("R3 unmapped 400");
    check(hits[0] + hits[1] + hits[2] == s, "R3 no window hit", 32'(hits[0] + hits[1] + hits[2]), 32'(s));
    check(!memSwReset, "R3 soft reset untouched", 32'(memSwReset), 32'h0);
    readWord(12'h300, d, "R3 status");
    check(d[0] == 1'b0, "R3 status bit0 untouched", d, 32'h0);
  endtask

  task automatic testStatus();
    logic [31:0] d;
    memInitIn = 2'b10;
    sendAwW(12'h300, 32'hFFFF_FFFF, 4'hF);
    waitB("R5 set");
    check(memSwReset, "R5 soft reset set", 32'(memSwReset), 32'h1);
    readWord(12'h300, d, "R4 status");
    check(d == 32'h5, "R4 status word", d, 32'h5);
    sendAwW(12'h300, 32'h0, 4'b1110);
    waitB("R5 strobe off");
    check(memSwReset, "R5 no strobe keeps value", 32'(memSwReset), 32'h1);
    sendAwW(12'h300, 32'hFFFF_FFFE, 4'h1);
    waitB("R5 clear");
    check(!memSwReset, "R5 soft reset cleared", 32'(memSwReset), 32'h0);
    memInitIn = 2'b01;
    repeat (3) @(negedge clk);
    readWord(12'h302, d, "R4 status alias");
    check(d == 32'h2, "R4 status init bits", d, 32'h2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testWinRead();
    testWinWrite();
    testUnmappedRead();
    testUnmappedWrite();
    testStatus();
    repeat (2) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule